// File: doc/BRIEF.md
# Peer Doorbell Interrupt Register Block

This block sits on a 32-bit register bus inside a node that shares memory with other nodes (peers). Software uses it in two directions. To signal another peer, software writes a doorbell word that names a target peer and a vector. The block checks that word against a local table of connected peers and their vector counts. When the word is valid, the block issues a one-cycle signal request to the transport. Requests that fail the check are dropped silently.

In the other direction, signals arriving from peers are recorded. In level mode, an incoming signal sets a status flag, and that flag drives a level interrupt through a mask. In message-signalled mode, the level output is held low and the signal sets a sticky pending bit for its vector.

A small link state machine controls when the block is ready. It has three states:

- LNK_OFF: interrupts are not configured.
- LNK_WAIT: interrupts are configured but setup is not complete.
- LNK_READY: setup is complete.

The machine has four transitions:

- T_ENABLE: LNK_OFF to LNK_WAIT, when interrupts become configured.
- T_DISABLE: any state to LNK_OFF, when the configuration is removed.
- T_SETUP: LNK_WAIT to LNK_READY, when setup-done is seen without setup-lost. The local ID is latched here.
- T_LOST: LNK_READY to LNK_WAIT, when setup-lost is seen.

Reset enters LNK_WAIT. The position register reports the link state. Doorbells and incoming signals take effect only in LNK_READY.

Top module: `peer_bell_regs`

## Requirements
- R1: After reset, the following hold: mask and status read 0, no pending bits are set, `ring_valid` and `irq_level` are low, and the position register reads 0xFFFFFFFF while `cfg_intr_en` is 1.
- R2: The mask register is at offset 0x00. Only bit 0 is stored. Reads return bit 0, with bits 31..1 reading 0.
- R3: The status register is at offset 0x04. A read returns its value and clears bit 0 on that cycle's edge. A write loads bit 0 from `reg_wdata[0]`. An incoming level signal on the same edge takes priority over both the write and the read clear.
- R4: In level mode (`cfg_msg_mode`=0), an incoming signal in the ready state sets status bit 0. `irq_level` equals status bit 0 AND mask bit 0. Incoming signals outside the ready state are ignored.
- R5: In message-signalled mode (`cfg_msg_mode`=1), `irq_level` stays 0. An incoming signal with vector v below 8 sets `msg_pending[v]` and leaves status unchanged. Vectors of 8 or above are ignored.
- R6: Pending bits are cleared only by reset. No register read or write clears them.
- R7: The position register is at offset 0x08 and is read-only. It reads 0 when `cfg_intr_en`=0 and 0xFFFFFFFF until setup completes. After that it reads `{16'h0, id}`, where id is the `local_id` latched at the `setup_done` edge.
- R8: `setup_lost` returns the block from the ready state to the waiting state. In the waiting state the position register reads 0xFFFFFFFF and doorbells are dropped. If `setup_lost` and `setup_done` are high on the same edge, `setup_lost` wins.
- R9: The doorbell is at offset 0x0C. Bits 31..16 hold the target peer ID and bits 15..0 the vector. An accepted write raises `ring_valid` for exactly the one cycle after the write edge. During that cycle `ring_peer` and `ring_vec` carry the written fields.
- R10: A doorbell write is dropped, with no `ring_valid`, in any of these cases: interrupts are not configured, the block is not ready, no valid table slot holds the target ID, or the vector is not below that slot's vector count.
- R11: A table write (`tbl_we`) loads the slot selected by `tbl_slot` with a valid flag, an ID and a vector count. Counts above 8 are stored as 8. Clearing the valid flag disconnects that peer.
- R12: Offsets other than 0x00, 0x04, 0x08 and 0x0C read 0, and writes to them have no effect. The doorbell reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_intr_en | input | 1 | Interrupts configured |
| cfg_msg_mode | input | 1 | Message-signalled mode select |
| local_id | input | 16 | ID assigned to this node |
| setup_done | input | 1 | Setup complete pulse |
| setup_lost | input | 1 | Setup regressed pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| tbl_we | input | 1 | Peer table write |
| tbl_slot | input | 4 | Peer table slot |
| tbl_valid | input | 1 | Slot connected flag |
| tbl_peer_id | input | 16 | Slot peer ID |
| tbl_vec_cnt | input | 4 | Slot vector count |
| sig_in_valid | input | 1 | Incoming peer signal |
| sig_in_vec | input | 16 | Incoming signal vector |
| ring_valid | output | 1 | Outgoing signal request |
| ring_peer | output | 16 | Request target peer |
| ring_vec | output | 16 | Request vector |
| irq_level | output | 1 | Level interrupt |
| msg_pending | output | 8 | Per-vector pending bits |

## Verification
The bench targets the doorbell boundaries:

- A vector equal to the slot's count, or a slot with a count of zero, must be dropped. A design using less-or-equal would ring anyway.
- A count written above 8 must clamp, so vector 8 is dropped after a count of 15.

It also targets the position register across disable, setup-lost, and a setup-lost/setup-done collision. A wrong priority there would report a stale ID and accept doorbells. Status must clear on the second read. Pending bits must survive writes to every offset, and out-of-range vectors must not alias into the pending bits. Finally, `irq_level` must stay low in message-signalled mode even with status and mask both set.

// File: rtl/peer_bell_pkg.sv
package peer_bell_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_MASK = 8'h00;
    localparam logic [REG_AW-1:0] OFF_STAT = 8'h04;
    localparam logic [REG_AW-1:0] OFF_POS  = 8'h08;
    localparam logic [REG_AW-1:0] OFF_BELL = 8'h0C;

    typedef enum logic [1:0] {
        LNK_OFF   = 2'd0,
        LNK_WAIT  = 2'd1,
        LNK_READY = 2'd2
    } link_state_e;

    typedef struct packed {
        logic [15:0] peer;
        logic [15:0] vec;
    } bell_req_t;

endpackage

// File: rtl/pb_link_fsm.sv
module pb_link_fsm
    import peer_bell_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        intr_en,
    input  logic        setup_done,
    input  logic        setup_lost,
    input  logic [15:0] local_id,
    output logic        ready,
    output logic [31:0] pos_value
);

    link_state_e state_q, state_d;
    logic [15:0] id_q;
    logic        take_id;

    // next-state logic with named transitions
    always_comb begin
        state_d = state_q;
        take_id = 1'b0;
        unique case (state_q)
            LNK_OFF: begin
                if (intr_en) state_d = LNK_WAIT;                  // T_ENABLE
            end
            LNK_WAIT: begin
                if (!intr_en) state_d = LNK_OFF;                  // T_DISABLE
                else if (setup_done && !setup_lost) begin         // T_SETUP
                    state_d = LNK_READY;
                    take_id = 1'b1;
                end
            end
            LNK_READY: begin
                if (!intr_en) state_d = LNK_OFF;                  // T_DISABLE
                else if (setup_lost) state_d = LNK_WAIT;          // T_LOST
            end
            default: state_d = LNK_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LNK_WAIT;
            id_q    <= 16'h0;
        end else begin
            state_q <= state_d;
            if (take_id) id_q <= local_id;
        end
    end

    // outputs
    always_comb begin
        ready     = 1'b0;
        pos_value = 32'hFFFF_FFFF;
        if (!intr_en) begin
            pos_value = 32'h0;
        end else begin
            unique case (state_q)
                LNK_READY: begin
                    ready     = 1'b1;
                    pos_value = {16'h0, id_q};
                end
                default: pos_value = 32'hFFFF_FFFF;
            endcase
        end
    end

    // R8: setup-lost in the ready state always leaves it
    a_r8_lost_leaves_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_READY && intr_en && setup_lost) |=> (state_q == LNK_WAIT));

    // R7: latched ID holds while the link stays ready
    a_r7_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_READY) |=> (state_q != LNK_READY || $stable(id_q)));

endmodule

// File: rtl/pb_peer_table.sv
module pb_peer_table #(
    parameter int NUM_PEERS = 16,
    parameter int MAX_VEC   = 8,
    localparam int SLOT_W   = $clog2(NUM_PEERS),
    localparam int CNT_W    = $clog2(MAX_VEC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [SLOT_W-1:0] tbl_slot,
    input  logic              tbl_valid,
    input  logic [15:0]       tbl_peer_id,
    input  logic [CNT_W-1:0]  tbl_vec_cnt,
    input  logic [15:0]       q_peer,
    input  logic [15:0]       q_vec,
    output logic              q_hit
);

    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_VEC);

    logic [NUM_PEERS-1:0] vld_q;
    logic [NUM_PEERS-1:0] match;
    logic [CNT_W-1:0]     cnt_in;

    assign cnt_in = (tbl_vec_cnt > CNT_CAP) ? CNT_CAP : tbl_vec_cnt;

    for (genvar s = 0; s < NUM_PEERS; s++) begin : g_slot
        logic [15:0]      id_q;
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                id_q     <= 16'h0;
                cnt_q    <= '0;
            end else if (tbl_we && tbl_slot == SLOT_W'(s)) begin
                vld_q[s] <= tbl_valid;
                id_q     <= tbl_peer_id;
                cnt_q    <= cnt_in;
            end
        end

        assign match[s] = vld_q[s] && (id_q == q_peer) &&
                          (q_vec < {{(16-CNT_W){1'b0}}, cnt_q});
    end

    assign q_hit = |match;

    // R11: a table write lands in the selected slot
    a_r11_slot_load: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> (vld_q[$past(tbl_slot)] == $past(tbl_valid)));

endmodule

// File: rtl/pb_irq_unit.sv
module pb_irq_unit #(
    parameter int NUM_LVEC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msg_mode,
    input  logic                sig_ok,
    input  logic [15:0]         sig_vec,
    input  logic                mask_we,
    input  logic                stat_we,
    input  logic                stat_rd,
    input  logic                wbit,
    output logic                mask_q,
    output logic                stat_q,
    output logic [NUM_LVEC-1:0] pend_q,
    output logic                irq_level
);

    logic sig_lvl, sig_msi;

    assign sig_lvl = sig_ok && !msg_mode;
    assign sig_msi = sig_ok && msg_mode && (sig_vec < 16'(NUM_LVEC));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            if (mask_we) mask_q <= wbit;
            if (sig_lvl)      stat_q <= 1'b1;
            else if (stat_we) stat_q <= wbit;
            else if (stat_rd) stat_q <= 1'b0;
        end
    end

    for (genvar v = 0; v < NUM_LVEC; v++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n)                              pend_q[v] <= 1'b0;
            else if (sig_msi && sig_vec == 16'(v))   pend_q[v] <= 1'b1;
        end
    end

    assign irq_level = !msg_mode && stat_q && mask_q;

    // R3: a lone read clears status
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !sig_lvl && !stat_we) |=> !stat_q);

    // R4: a level signal sets status
    a_r4_sig_sets: assert property (@(posedge clk) disable iff (!rst_n)
        sig_lvl |=> stat_q);

    // R5: message-signalled arrivals never touch status
    a_r5_msi_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_mode && sig_ok && !stat_we && !stat_q) |=> !stat_q);

    // R6: pending bits never fall
    a_r6_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/peer_bell_regs.sv
module peer_bell_regs
    import peer_bell_pkg::*;
#(
    parameter int NUM_PEERS = 16,
    parameter int MAX_VEC   = 8,
    parameter int NUM_LVEC  = 8,
    localparam int SLOT_W   = $clog2(NUM_PEERS),
    localparam int CNT_W    = $clog2(MAX_VEC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_intr_en,
    input  logic                cfg_msg_mode,
    input  logic [15:0]         local_id,
    input  logic                setup_done,
    input  logic                setup_lost,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                tbl_we,
    input  logic [SLOT_W-1:0]   tbl_slot,
    input  logic                tbl_valid,
    input  logic [15:0]         tbl_peer_id,
    input  logic [CNT_W-1:0]    tbl_vec_cnt,
    input  logic                sig_in_valid,
    input  logic [15:0]         sig_in_vec,
    output logic                ring_valid,
    output logic [15:0]         ring_peer,
    output logic [15:0]         ring_vec,
    output logic                irq_level,
    output logic [NUM_LVEC-1:0] msg_pending
);

    logic        ready;
    logic [31:0] pos_value;
    logic        bell_wr, bell_ok, peer_hit;
    logic        mask_q, stat_q;
    bell_req_t   bell_in, ring_q;
    logic        ring_vld_q;

    pb_link_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .intr_en    (cfg_intr_en),
        .setup_done (setup_done),
        .setup_lost (setup_lost),
        .local_id   (local_id),
        .ready      (ready),
        .pos_value  (pos_value)
    );

    assign bell_in = bell_req_t'(reg_wdata);
    assign bell_wr = reg_wr && (reg_addr == OFF_BELL);

    pb_peer_table #(.NUM_PEERS(NUM_PEERS), .MAX_VEC(MAX_VEC)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbl_we      (tbl_we),
        .tbl_slot    (tbl_slot),
        .tbl_valid   (tbl_valid),
        .tbl_peer_id (tbl_peer_id),
        .tbl_vec_cnt (tbl_vec_cnt),
        .q_peer      (bell_in.peer),
        .q_vec       (bell_in.vec),
        .q_hit       (peer_hit)
    );

    pb_irq_unit #(.NUM_LVEC(NUM_LVEC)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_mode  (cfg_msg_mode),
        .sig_ok    (sig_in_valid && ready),
        .sig_vec   (sig_in_vec),
        .mask_we   (reg_wr && reg_addr == OFF_MASK),
        .stat_we   (reg_wr && reg_addr == OFF_STAT),
        .stat_rd   (reg_rd && reg_addr == OFF_STAT),
        .wbit      (reg_wdata[0]),
        .mask_q    (mask_q),
        .stat_q    (stat_q),
        .pend_q    (msg_pending),
        .irq_level (irq_level)
    );

    assign bell_ok = bell_wr && ready && peer_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_vld_q <= 1'b0;
            ring_q     <= '0;
        end else begin
            ring_vld_q <= bell_ok;
            if (bell_ok) ring_q <= bell_in;
        end
    end

    assign ring_valid = ring_vld_q;
    assign ring_peer  = ring_q.peer;
    assign ring_vec   = ring_q.vec;

    always_comb begin
        unique case (reg_addr)
            OFF_MASK: reg_rdata = {31'h0, mask_q};
            OFF_STAT: reg_rdata = {31'h0, stat_q};
            OFF_POS:  reg_rdata = pos_value;
            default:  reg_rdata = 32'h0;
        endcase
    end

    // R9: a request only follows a doorbell write
    a_r9_ring_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ring_valid |-> $past(bell_wr));

    // R10: no request while the link is not ready
    a_r10_drop_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_wr && !ready) |=> !ring_valid);

endmodule

// File: tb/peer_bell_regs_tb.sv
`timescale 1ns/1ps
module peer_bell_regs_tb;

    typedef struct packed {
        logic [2:0]  op;   // 0 WR,1 RD,2 BELL hit,3 BELL drop,4 SIG,5 IRQ
        logic [3:0]  req;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        {3'd1, 4'd7,  8'h08, 32'h0,        32'h42},  // R7 id
        {3'd0, 4'd7,  8'h08, 32'hFFFF,     32'h0},   // R7 write ignored
        {3'd1, 4'd7,  8'h08, 32'h0,        32'h42},  // R7
        {3'd0, 4'd2,  8'h00, 32'hFFFFFFFF, 32'h0},   // R2
        {3'd1, 4'd2,  8'h00, 32'h0,        32'h1},   // R2 bit0 only
        {3'd2, 4'd9,  8'h0C, 32'h00050001, 32'h0},   // R9 hit
        {3'd3, 4'd10, 8'h0C, 32'h00050002, 32'h0},   // R10 vec == count
        {3'd2, 4'd9,  8'h0C, 32'h12340007, 32'h0},   // R9 top vector
        {3'd3, 4'd10, 8'h0C, 32'h12340008, 32'h0},   // R10
        {3'd3, 4'd10, 8'h0C, 32'h00090000, 32'h0},   // R10 zero count
        {3'd3, 4'd10, 8'h0C, 32'h00060000, 32'h0},   // R10 absent peer
        {3'd0, 4'd12, 8'h10, 32'hFFFFFFFF, 32'h0},   // R12
        {3'd1, 4'd12, 8'h10, 32'h0,        32'h0},   // R12
        {3'd1, 4'd12, 8'hFC, 32'h0,        32'h0},   // R12
        {3'd1, 4'd12, 8'h0C, 32'h0,        32'h0},   // R12 doorbell reads 0
        {3'd5, 4'd4,  8'h00, 32'h0,        32'h0},   // R4 no irq yet
        {3'd4, 4'd4,  8'h00, 32'h3,        32'h0},   // R4 incoming
        {3'd5, 4'd4,  8'h00, 32'h0,        32'h1},   // R4 irq up
        {3'd1, 4'd3,  8'h04, 32'h0,        32'h1},   // R3 read
        {3'd1, 4'd3,  8'h04, 32'h0,        32'h0},   // R3 cleared
        {3'd5, 4'd4,  8'h00, 32'h0,        32'h0}    // R4 irq down
    };

    logic        clk = 0, rst_n = 0;
    logic        cfg_intr_en = 1, cfg_msg_mode = 0;
    logic [15:0] local_id = 16'h0042;
    logic        setup_done = 0, setup_lost = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        tbl_we = 0, tbl_valid = 0;
    logic [3:0]  tbl_slot = 0, tbl_vec_cnt = 0;
    logic [15:0] tbl_peer_id = 0;
    logic        sig_in_valid = 0;
    logic [15:0] sig_in_vec = 0;
    logic        ring_valid, irq_level;
    logic [15:0] ring_peer, ring_vec;
    logic [7:0]  msg_pending;

    int n_chk = 0, n_bad = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    peer_bell_regs u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_intr_en(cfg_intr_en), .cfg_msg_mode(cfg_msg_mode),
        .local_id(local_id), .setup_done(setup_done), .setup_lost(setup_lost),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_valid(tbl_valid),
        .tbl_peer_id(tbl_peer_id), .tbl_vec_cnt(tbl_vec_cnt), .sig_in_valid(sig_in_valid),
        .sig_in_vec(sig_in_vec), .ring_valid(ring_valid), .ring_peer(ring_peer),
        .ring_vec(ring_vec), .irq_level(irq_level), .msg_pending(msg_pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic bell(input string req, input logic [31:0] d, input logic hit);
        wr(8'h0C, d);
        chk(req, {31'h0, ring_valid}, {31'h0, hit});
        if (hit) chk(req, {ring_peer, ring_vec}, d);
    endtask

    task automatic sig(input logic [15:0] v);
        sig_in_valid = 1; sig_in_vec = v;
        @(negedge clk);
        sig_in_valid = 0;
    endtask

    task automatic load(input logic [3:0] s, input logic vl, input logic [15:0] id, input logic [3:0] c);
        tbl_we = 1; tbl_slot = s; tbl_valid = vl; tbl_peer_id = id; tbl_vec_cnt = c;
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic pulse(input logic done, input logic lost);
        setup_done = done; setup_lost = lost;
        @(negedge clk);
        setup_done = 0; setup_lost = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(8'h08, rv); chk("R1", rv, 32'hFFFFFFFF);
        rd(8'h00, rv); chk("R1", rv, 32'h0);
        rd(8'h04, rv); chk("R1", rv, 32'h0);
        chk("R1", {22'h0, msg_pending, ring_valid, irq_level}, 32'h0);

        // R7/R10 unconfigured
        cfg_intr_en = 0;
        #1 chk("R7", reg_rdata & 32'h0, 32'h0);
        rd(8'h08, rv); chk("R7", rv, 32'h0);
        load(4'd0, 1, 16'h0005, 4'd2);
        bell("R10", 32'h00050000, 0);
        cfg_intr_en = 1;
        @(negedge clk);
        load(4'd3, 1, 16'h1234, 4'd8);
        load(4'd7, 1, 16'h0009, 4'd0);
        bell("R10", 32'h00050000, 0);   // not ready yet
        pulse(1, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            vec_t v;
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", v.req, i);
            case (v.op)
                3'd0: wr(v.addr, v.data);
                3'd1: begin rd(v.addr, rv); chk(tag, rv, v.exp); end
                3'd2: bell(tag, v.data, 1);
                3'd3: bell(tag, v.data, 0);
                3'd4: sig(v.data[15:0]);
                default: chk(tag, {31'h0, irq_level}, v.exp);
            endcase
        end

        // R8 setup lost
        pulse(0, 1);
        rd(8'h08, rv); chk("R8", rv, 32'hFFFFFFFF);
        bell("R8", 32'h00050001, 0);
        sig(16'h0);                                    // R4 ignored when not ready
        rd(8'h04, rv); chk("R4", rv, 32'h0);
        pulse(1, 1);
        rd(8'h08, rv); chk("R8", rv, 32'hFFFFFFFF);
        pulse(1, 0);
        rd(8'h08, rv); chk("R7", rv, 32'h42);

        // R5/R6 message-signalled mode
        cfg_msg_mode = 1;
        wr(8'h04, 32'h1);
        chk("R5", {31'h0, irq_level}, 32'h0);
        rd(8'h04, rv); chk("R3", rv, 32'h1);
        sig(16'd2);
        chk("R5", {24'h0, msg_pending}, 32'h04);
        rd(8'h04, rv); chk("R5", rv, 32'h0);
        sig(16'd9);
        chk("R5", {24'h0, msg_pending}, 32'h04);
        for (int a = 0; a < 16; a += 4) begin
            wr(8'(a), 32'hFFFFFFFF);
            rd(8'(a), rv);
        end
        chk("R6", {24'h0, msg_pending}, 32'h04);
        chk("R5", {31'h0, irq_level}, 32'h0);

        // R11 table updates
        load(4'd0, 0, 16'h0005, 4'd2);
        bell("R11", 32'h00050000, 0);
        load(4'd0, 1, 16'h0005, 4'd15);
        bell("R11", 32'h00050007, 1);
        bell("R11", 32'h00050008, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule